// File: doc/BRIEF.md
# Receive Frame Integrity Checker

This block sits behind a receive MAC and takes the raw byte stream of each received frame, beginning with the preamble. It discards the preamble and the start-of-frame delimiter and writes the frame bytes into an internal packet store. While the bytes arrive it runs an Ethernet CRC-32 over them, counts the length, and captures the logical link identifier from the destination MAC address. A frame is released for output only once its last byte has been stored and every check has passed. A frame that fails a check is erased by moving the store's write pointer back to where that frame began, so no part of it is ever read out.

Accepted frames are routed by their link identifier. A small table that can be written at run time maps identifiers to output ports. Each accepted frame leaves the block as a contiguous byte burst, one byte per cycle, and every byte carries the port tag. The block keeps one count of accepted frames and one count of rejected frames. Nothing is signalled at the output for a rejected frame.

Top module: `frame_gate`

## Requirements
- R1: Bytes that come before the delimiter 0xD5 (preamble bytes 0x55) are not stored. The byte that follows the delimiter is frame byte 0. Each forwarded frame leaves the block as exactly the bytes after the delimiter, FCS included, in arrival order, and out_last is high on the final byte only.
- R2: No byte of a frame appears at the output before the last byte of that frame has been received.
- R3: The CRC is the reflected Ethernet CRC-32 (polynomial 0xEDB88320, register preset to all ones). The sender appends the complemented CRC, low byte first. It runs over every stored byte including the FCS. A frame whose final register differs from the bit-reversed residue 0xC704DD7B is dropped and counted as bad.
- R4: A frame of fewer than 64 stored bytes, FCS included, is dropped and counted as bad. A frame of exactly 64 bytes is accepted.
- R5: The link identifier is {frame byte 4, frame byte 5}, with byte 4 as the high half. The valid table entry with the lowest index whose identifier matches supplies out_port, and out_port holds that value on every byte of the frame.
- R6: A frame whose identifier matches no valid table entry is dropped and counted as bad.
- R7: A frame that does not fit in the free space of the packet store is dropped and counted as bad. Frames that follow it are not affected.
- R8: A frame that ends (in_last) before any delimiter has been seen is discarded and counted as bad.
- R9: After reset, out_valid is low and both counters are zero. good_count rises by one for each forwarded frame and bad_count by one for each dropped frame.
- R10: cfg_we writes cfg_valid, cfg_id and cfg_port into entry cfg_idx. An entry written with cfg_valid low never matches.
- R11: Frames sent back to back with no idle cycles are all forwarded without loss while output of earlier frames is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte, preamble onward |
| in_last | input | 1 | Marks the last byte of a received frame |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_idx | input | $clog2(ENTRIES) | Table entry index |
| cfg_valid | input | 1 | Entry enable written with the entry |
| cfg_id | input | 16 | Link identifier of the entry |
| cfg_port | input | PORT_W | Output port of the entry |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Last byte of an output frame |
| out_port | output | PORT_W | Port tag of the current output frame |
| good_count | output | CNT_W | Accepted frame count |
| bad_count | output | CNT_W | Dropped frame count |

## Verification
A store pointer left in the wrong place after a drop shows up on the next accepted frame. Its bytes come out shifted or carry a stale tail, and a byte-by-byte comparison catches this at that frame's out_last. A residue or length check that is off by one byte or one bit either forwards a frame that should have been dropped or drops one that should have passed. The bench sees this as an unexpected frame or a missing one, and the two counters disagree with the model at the next drain point. A bad table decode gives a wrong out_port on the first byte of the affected frame.

// File: rtl/fg_pkg.sv
package fg_pkg;
   localparam logic [7:0]  SFD_BYTE      = 8'hD5;
   localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

   typedef enum logic {ST_HUNT, ST_BODY} rx_state_e;

   // One byte of the reflected CRC-32, least significant bit first.
   function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r;
      r = c;
      for (int i = 0; i < 8; i++) begin
         if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
         else             r = r >> 1;
      end
      return r;
   endfunction

   function automatic logic [31:0] bit_rev32(input logic [31:0] v);
      logic [31:0] r;
      for (int i = 0; i < 32; i++) r[i] = v[31-i];
      return r;
   endfunction
endpackage

// File: rtl/fg_event_counter.sv
module fg_event_counter #(
   parameter int W        = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] value
);
   localparam logic [W-1:0] TOP = '1;

   logic [W-1:0] nxt;

   generate
      if (SATURATE) begin : g_sat
         always_comb nxt = (value == TOP) ? value : value + 1'b1;
      end else begin : g_wrap
         always_comb nxt = value + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   value <= '0;
      else if (inc) value <= nxt;
   end

   initial assert (W >= 2) else $error("fg_event_counter: W too small");

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && value != TOP) |=> value == $past(value) + 1'b1); // R9
endmodule

// File: rtl/fg_link_table.sv
module fg_link_table #(
   parameter int ENTRIES = 8,
   parameter int ID_W    = 16,
   parameter int PORT_W  = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_we,
   input  logic [$clog2(ENTRIES)-1:0] cfg_idx,
   input  logic                       cfg_valid,
   input  logic [ID_W-1:0]            cfg_id,
   input  logic [PORT_W-1:0]          cfg_port,
   input  logic [ID_W-1:0]            key,
   output logic                       hit,
   output logic [PORT_W-1:0]          port
);
   localparam int IW = $clog2(ENTRIES);

   logic [ENTRIES-1:0]        match;
   logic [ENTRIES*PORT_W-1:0] port_flat;

   initial assert (ENTRIES >= 2) else $error("fg_link_table: need at least two entries");

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic              v;
      logic [ID_W-1:0]   id;
      logic [PORT_W-1:0] prt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v   <= 1'b0;
            id  <= '0;
            prt <= '0;
         end else if (cfg_we && cfg_idx == IW'(e)) begin
            v   <= cfg_valid;
            id  <= cfg_id;
            prt <= cfg_port;
         end
      end
      assign match[e] = v && (id == key);
      assign port_flat[e*PORT_W +: PORT_W] = prt;
   end

   // Lowest matching index wins.
   always_comb begin
      hit  = |match;
      port = '0;
      for (int e = ENTRIES-1; e >= 0; e--) begin
         if (match[e]) port = port_flat[e*PORT_W +: PORT_W];
      end
   end
endmodule

// File: rtl/fg_store.sv
module fg_store #(
   parameter int DEPTH     = 256,
   parameter int TAG_DEPTH = 4,
   parameter int PORT_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [7:0]        wr_data,
   input  logic              wr_last,
   input  logic              commit,
   input  logic              drop,
   input  logic [PORT_W-1:0] commit_port,
   output logic              full,
   output logic              ovf,
   output logic              tag_full,
   output logic              out_valid,
   output logic [7:0]        out_data,
   output logic              out_last,
   output logic [PORT_W-1:0] out_port
);
   localparam int AW = $clog2(DEPTH);
   localparam int TW = $clog2(TAG_DEPTH);

   initial assert ((DEPTH & (DEPTH-1)) == 0 && DEPTH >= 16)
      else $error("fg_store: DEPTH must be a power of two");
   initial assert ((TAG_DEPTH & (TAG_DEPTH-1)) == 0 && TAG_DEPTH >= 2)
      else $error("fg_store: TAG_DEPTH must be a power of two");

   logic [8:0]        mem [DEPTH];
   logic [AW:0]       wr_ptr, rd_ptr, start_ptr, used, wr_adv;
   logic              ovf_q;
   logic [PORT_W-1:0] tag_mem [TAG_DEPTH];
   logic [TW:0]       tag_wr, tag_rd, tag_cnt;
   logic              busy, pop;
   logic [PORT_W-1:0] cur_port;
   logic [8:0]        rd_word;

   assign used     = wr_ptr - rd_ptr;
   assign full     = (used == (AW+1)'(DEPTH));
   assign ovf      = ovf_q;
   assign wr_adv   = wr_ptr + (AW+1)'(wr_en && !full);
   assign tag_cnt  = tag_wr - tag_rd;
   assign tag_full = (tag_cnt == (TW+1)'(TAG_DEPTH));
   assign pop      = !busy && (tag_cnt != '0);
   assign rd_word  = mem[rd_ptr[AW-1:0]];

   always_ff @(posedge clk) begin
      if (wr_en && !full) mem[wr_ptr[AW-1:0]] <= {wr_last, wr_data};
   end

   always_ff @(posedge clk) begin
      if (commit) tag_mem[tag_wr[TW-1:0]] <= commit_port;
   end

   // Write side: a dropped frame rewinds to its own start.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr    <= '0;
         start_ptr <= '0;
         ovf_q     <= 1'b0;
         tag_wr    <= '0;
      end else if (drop) begin
         wr_ptr <= start_ptr;
         ovf_q  <= 1'b0;
      end else if (commit) begin
         wr_ptr    <= wr_adv;
         start_ptr <= wr_adv;
         ovf_q     <= 1'b0;
         tag_wr    <= tag_wr + 1'b1;
      end else begin
         wr_ptr <= wr_adv;
         if (wr_en && full) ovf_q <= 1'b1;
      end
   end

   // Read side: one committed frame at a time, one byte per cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         cur_port  <= '0;
         rd_ptr    <= '0;
         tag_rd    <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
         out_last  <= 1'b0;
         out_port  <= '0;
      end else begin
         out_valid <= busy;
         if (pop) begin
            busy     <= 1'b1;
            cur_port <= tag_mem[tag_rd[TW-1:0]];
            tag_rd   <= tag_rd + 1'b1;
         end
         if (busy) begin
            out_data <= rd_word[7:0];
            out_last <= rd_word[8];
            out_port <= cur_port;
            rd_ptr   <= rd_ptr + 1'b1;
            if (rd_word[8]) busy <= 1'b0;
         end else begin
            out_last <= 1'b0;
         end
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      used <= (AW+1)'(DEPTH)); // R7
   AST_DROP_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> wr_ptr == $past(start_ptr)); // R7
   AST_PORT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_last) |=> (out_valid && $stable(out_port))); // R5
   AST_TAG_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> !tag_full); // R11
endmodule

// File: rtl/frame_gate.sv
module frame_gate
   import fg_pkg::*;
#(
   parameter int          DEPTH     = 256,
   parameter int          TAG_DEPTH = 4,
   parameter int          ENTRIES   = 8,
   parameter int          PORT_W    = 3,
   parameter int          CNT_W     = 16,
   parameter int          MIN_LEN   = 64,
   parameter logic [31:0] MAGIC     = 32'hC704DD7B,
   parameter bit          SATURATE  = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic [7:0]                 in_data,
   input  logic                       in_last,
   input  logic                       cfg_we,
   input  logic [$clog2(ENTRIES)-1:0] cfg_idx,
   input  logic                       cfg_valid,
   input  logic [15:0]                cfg_id,
   input  logic [PORT_W-1:0]          cfg_port,
   output logic                       out_valid,
   output logic [7:0]                 out_data,
   output logic                       out_last,
   output logic [PORT_W-1:0]          out_port,
   output logic [CNT_W-1:0]           good_count,
   output logic [CNT_W-1:0]           bad_count
);
   localparam int             LEN_W   = $clog2(DEPTH + MIN_LEN) + 1;
   localparam logic [LEN_W-1:0] LEN_MAX = '1;
   localparam logic [31:0]    RESIDUE = bit_rev32(MAGIC);

   initial assert (MIN_LEN >= 6 && MIN_LEN <= DEPTH)
      else $error("frame_gate: MIN_LEN out of range");

   rx_state_e         state;
   logic [31:0]       crc_q, crc_nxt;
   logic [LEN_W-1:0]  len_q, len_nxt;
   logic [15:0]       id_q;
   logic              hunt_sfd, hunt_end, body_wr, frame_end;
   logic              len_ok, crc_ok, accept, reject;
   logic              tbl_hit;
   logic [PORT_W-1:0] tbl_port;
   logic              st_full, st_ovf, st_tag_full;
   logic              good_inc, bad_inc;

   assign hunt_sfd  = (state == ST_HUNT) && in_valid && !in_last && (in_data == SFD_BYTE);
   assign hunt_end  = (state == ST_HUNT) && in_valid && in_last;
   assign body_wr   = (state == ST_BODY) && in_valid;
   assign frame_end = body_wr && in_last;
   assign crc_nxt   = crc_step(crc_q, in_data);
   assign len_nxt   = (len_q == LEN_MAX) ? len_q : len_q + 1'b1;
   assign len_ok    = len_nxt >= LEN_W'(MIN_LEN);
   assign crc_ok    = (crc_nxt == RESIDUE);
   assign accept    = frame_end && len_ok && crc_ok && tbl_hit
                      && !st_full && !st_ovf && !st_tag_full;
   assign reject    = frame_end && !accept;
   assign good_inc  = accept;
   assign bad_inc   = reject || hunt_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_HUNT;
         crc_q <= '1;
         len_q <= '0;
         id_q  <= '0;
      end else begin
         case (state)
            ST_HUNT: begin
               if (hunt_sfd) begin
                  state <= ST_BODY;
                  crc_q <= '1;
                  len_q <= '0;
               end
            end
            ST_BODY: begin
               if (body_wr) begin
                  crc_q <= crc_nxt;
                  len_q <= len_nxt;
                  if (len_q == LEN_W'(4)) id_q[15:8] <= in_data;
                  if (len_q == LEN_W'(5)) id_q[7:0]  <= in_data;
                  if (in_last) state <= ST_HUNT;
               end
            end
            default: state <= ST_HUNT;
         endcase
      end
   end

   fg_link_table #(.ENTRIES(ENTRIES), .ID_W(16), .PORT_W(PORT_W)) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_idx   (cfg_idx),
      .cfg_valid (cfg_valid),
      .cfg_id    (cfg_id),
      .cfg_port  (cfg_port),
      .key       (id_q),
      .hit       (tbl_hit),
      .port      (tbl_port)
   );

   fg_store #(.DEPTH(DEPTH), .TAG_DEPTH(TAG_DEPTH), .PORT_W(PORT_W)) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (body_wr),
      .wr_data     (in_data),
      .wr_last     (in_last),
      .commit      (accept),
      .drop        (reject),
      .commit_port (tbl_port),
      .full        (st_full),
      .ovf         (st_ovf),
      .tag_full    (st_tag_full),
      .out_valid   (out_valid),
      .out_data    (out_data),
      .out_last    (out_last),
      .out_port    (out_port)
   );

   fg_event_counter #(.W(CNT_W), .SATURATE(SATURATE)) u_good (
      .clk (clk), .rst_n (rst_n), .inc (good_inc), .value (good_count)
   );

   fg_event_counter #(.W(CNT_W), .SATURATE(SATURATE)) u_bad (
      .clk (clk), .rst_n (rst_n), .inc (bad_inc), .value (bad_count)
   );

   AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({good_inc, bad_inc})); // R9
endmodule

// File: tb/tb_frame_gate.sv
module tb_frame_gate;
   localparam int DEPTH   = 256;
   localparam int ENTRIES = 8;
   localparam int PORT_W  = 3;
   localparam int CNT_W   = 16;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic              rst_n;
   logic              in_valid, in_last;
   logic [7:0]        in_data;
   logic              cfg_we, cfg_valid;
   logic [2:0]        cfg_idx;
   logic [15:0]       cfg_id;
   logic [PORT_W-1:0] cfg_port;
   logic              out_valid, out_last;
   logic [7:0]        out_data;
   logic [PORT_W-1:0] out_port;
   logic [CNT_W-1:0]  good_count, bad_count;

   frame_gate #(.DEPTH(DEPTH), .ENTRIES(ENTRIES), .PORT_W(PORT_W), .CNT_W(CNT_W)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid), .cfg_id(cfg_id),
      .cfg_port(cfg_port), .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
      .out_port(out_port), .good_count(good_count), .bad_count(bad_count)
   );

   int checks = 0, fails = 0;
   int exp_good = 0, exp_bad = 0;
   int acc_done = 0, started = 0;
   byte unsigned exp_q[$];
   int           exp_len[$];
   int           exp_port[$];
   byte unsigned got[$];
   int           got_port;
   byte unsigned fb[$];
   logic              tv   [ENTRIES];
   logic [15:0]       tid  [ENTRIES];
   logic [PORT_W-1:0] tport[ENTRIES];

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] crc_upd(input logic [31:0] c, input byte unsigned d);
      logic [31:0] r;
      r = c;
      for (int i = 0; i < 8; i++) begin
         if (r[0] ^ d[i]) r = (r >> 1) ^ 32'hEDB88320;
         else             r = r >> 1;
      end
      return r;
   endfunction

   function automatic int lookup(input logic [15:0] id);
      for (int e = 0; e < ENTRIES; e++) if (tv[e] && tid[e] == id) return int'(tport[e]);
      return -1;
   endfunction

   task automatic cfg_write(input int idx, input bit v, input logic [15:0] id, input int p);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_valid = v; cfg_id = id; cfg_port = PORT_W'(p);
      @(negedge clk);
      cfg_we = 1'b0;
      tv[idx] = v; tid[idx] = id; tport[idx] = PORT_W'(p);
   endtask

   task automatic drive_byte(input byte unsigned b, input bit l);
      @(negedge clk);
      in_valid = 1'b1; in_data = b; in_last = l;
   endtask

   task automatic go_idle(input int gap);
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
      repeat (gap) @(negedge clk);
   endtask

   // n payload bytes, then FCS appended; expect_ovf marks a frame too big for the store
   task automatic send_frame(input int n, input logic [15:0] id, input bit corrupt,
                             input int gap, input bit expect_ovf);
      logic [31:0] c;
      int lp, pre;
      bit good;
      c = '1;
      fb.delete();
      for (int i = 0; i < n; i++) begin
         byte unsigned b;
         b = byte'($urandom);
         if (i == 4) b = id[15:8];
         if (i == 5) b = id[7:0];
         fb.push_back(b);
         c = crc_upd(c, b);
      end
      c = ~c;
      for (int k = 0; k < 4; k++) fb.push_back(c[8*k +: 8]);
      if (corrupt) begin
         int j;
         j = $urandom_range(fb.size()-1);
         fb[j] = fb[j] ^ 8'h10;
      end
      lp = lookup(id);
      good = !corrupt && fb.size() >= 64 && lp >= 0 && !expect_ovf;
      if (good) begin
         foreach (fb[i]) exp_q.push_back(fb[i]);
         exp_len.push_back(fb.size());
         exp_port.push_back(lp);
         exp_good++;
      end else begin
         exp_bad++;
      end
      pre = 1 + $urandom_range(6);
      repeat (pre) drive_byte(8'h55, 1'b0);
      drive_byte(8'hD5, 1'b0);
      foreach (fb[i]) drive_byte(fb[i], i == fb.size()-1);
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
      if (good) acc_done++;
      repeat (gap) @(negedge clk);
   endtask

   task automatic drain_and_count(input string tag);
      repeat (2*DEPTH + 20) @(negedge clk);
      check(exp_len.size() == 0, "R11", {tag, " frames still missing"}, exp_len.size(), 0);
      check(int'(good_count) == exp_good, "R9", {tag, " good_count"}, good_count, exp_good);
      check(int'(bad_count) == exp_bad, "R9", {tag, " bad_count"}, bad_count, exp_bad);
   endtask

   // Output monitor
   initial begin
      forever begin
         @(negedge clk);
         if (out_valid) begin
            if (got.size() == 0) begin
               got_port = int'(out_port);
               started++;
               check(started <= acc_done, "R2", "output began before frame end", started, acc_done);
            end else if (int'(out_port) != got_port) begin
               check(0, "R5", "port changed mid-frame", out_port, got_port);
            end
            got.push_back(out_data);
            if (out_last) begin
               if (exp_len.size() == 0) begin
                  check(0, "R3", "unexpected frame forwarded", got.size(), 0);
               end else begin
                  int n, p, bad;
                  n = exp_len.pop_front();
                  p = exp_port.pop_front();
                  bad = 0;
                  for (int i = 0; i < n; i++) begin
                     byte unsigned e;
                     e = exp_q.pop_front();
                     if (i >= got.size() || got[i] != e) bad++;
                  end
                  check(n == got.size() && bad == 0, "R1", "frame bytes/length", got.size(), n);
                  check(got_port == p, "R5", "port tag", got_port, p);
               end
               got.delete();
            end
         end
      end
   end

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      for (int e = 0; e < ENTRIES; e++) begin tv[e] = 0; tid[e] = '0; tport[e] = '0; end
      rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = '0;
      cfg_we = 1'b0; cfg_idx = '0; cfg_valid = 1'b0; cfg_id = '0; cfg_port = '0;
      repeat (5) @(negedge clk);
      check(out_valid == 1'b0, "R9", "out_valid in reset", out_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(good_count == '0 && bad_count == '0, "R9", "counters after reset",
            good_count + bad_count, 0);

      // R10: table setup; index 0 beats index 2 for the same id (R5), index 3 disabled
      cfg_write(0, 1, 16'h0101, 1);
      cfg_write(1, 1, 16'h0202, 2);
      cfg_write(2, 1, 16'h0101, 3);
      cfg_write(3, 0, 16'h0303, 4);

      send_frame(60, 16'h0101, 0, 4, 0);   // R4 exactly 64 bytes, R5 priority
      send_frame(59, 16'h0101, 0, 4, 0);   // R4 63 bytes dropped
      send_frame(76, 16'h0202, 1, 4, 0);   // R3 corrupted
      send_frame(70, 16'h0303, 0, 4, 0);   // R10 disabled entry
      send_frame(70, 16'h0404, 0, 4, 0);   // R6 no entry
      drain_and_count("directed");

      // R8: frame that ends inside the preamble
      drive_byte(8'h55, 0); drive_byte(8'h55, 0); drive_byte(8'h55, 1);
      go_idle(4);
      exp_bad++;
      drain_and_count("R8 headerless");

      // R7: oversized frame, then a normal one
      send_frame(300, 16'h0202, 0, 4, 1);
      send_frame(80, 16'h0202, 0, 4, 0);
      drain_and_count("R7 overflow");

      // R10: rewrite an entry and see the new port
      cfg_write(1, 1, 16'h0202, 5);
      send_frame(66, 16'h0202, 0, 2, 0);
      drain_and_count("R10 rewrite");

      // R11: back-to-back good frames
      for (int k = 0; k < 6; k++) send_frame(60 + 7*k, (k % 2) ? 16'h0202 : 16'h0101, 0, 0, 0);
      drain_and_count("R11 back-to-back");

      // Random mix
      for (int k = 0; k < 40; k++) begin
         logic [15:0] ids[4];
         ids[0] = 16'h0101; ids[1] = 16'h0202; ids[2] = 16'h0303; ids[3] = 16'h0404;
         send_frame(56 + $urandom_range(60), ids[$urandom_range(3)],
                    ($urandom_range(4) == 0), $urandom_range(3), 0);
      end
      drain_and_count("random");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule